// File: doc/BRIEF.md
# Serial Autobaud Lock and Acknowledge Unit

This block sits on an asynchronous serial receive line and waits for a host to send a single known synchronisation character, the at-sign (0x40). The line stays low for seven consecutive bit times, from the start bit through data bit 5. The block counts those low clocks and divides the count by seven, rounding to nearest, to learn one bit period. It then checks the rest of the character: data bit 6 high, data bit 7 low and a high stop bit. If the character is good, the block derives a 16-bit baud divisor and answers the host with a four-byte acknowledge frame. It sends that frame through its own transmitter, which runs at the measured bit period.

The active-low ready-to-send output stays deasserted (high), holding the host off, until the acknowledge has gone out and a local arm signal releases it. A too-short low period, an overlong one or a wrong tail pattern makes the block pulse its error output for one cycle and return to waiting. The flow-control input of a full UART has no role in this phase and is not a port.

States, each named: `ST_IDLE` (line watched), `ST_LOW` (low time counted), `ST_CHECK` (tail bits sampled at mid-bit), `ST_FAIL` (one-cycle error), `ST_ACK` (acknowledge bytes sent), `ST_HOLD` (acknowledge finished, host still held), `ST_OPEN` (host released).

Transitions, each named:
- IDLE→LOW: the synchronised line is seen low.
- LOW→IDLE: the line goes high before MIN_BIT/2 clocks, so the low is a glitch.
- LOW→FAIL: the line goes high with a low time under 7·MIN_BIT, or the count reaches 2^CNT_W−1 while the line is still low.
- LOW→CHECK: the line goes high after a valid low time.
- CHECK→FAIL: a sampled tail bit differs from high, low, high.
- CHECK→ACK: the stop bit sample is good.
- FAIL→IDLE: always.
- ACK→HOLD: the last stop bit of the fourth byte has ended.
- HOLD→OPEN: arm is high.

Top module: `autobaud_sync`

## Requirements
- R1: After reset, tx_o and rts_n_o are high, and lock_o, done_o and err_o are low. divisor_o is zero.
- R2: Take a 0x40 character framed 8N1 and sent LSB first with a bit period of P clocks, where P ≥ MIN_BIT and 7·P ≤ 2^CNT_W−1. After it, lock_o is high and divisor_o equals (P + 2^(OS_LOG2−1)) >> OS_LOG2. P is the low time divided by 7, rounded to nearest.
- R3: After locking, tx_o carries exactly four bytes, each framed 8N1, LSB first, with P clocks per bit. The bytes go in this order: 0xBF, divisor_o[7:0], divisor_o[15:8], 0x00. Before lock, tx_o stays high.
- R4: done_o rises after the stop bit of the fourth byte and stays high. tx_o is high while done_o is high.
- R5: rts_n_o stays high until done_o is high and arm_i is high together. An arm_i held high earlier has no effect before done_o. Once low, rts_n_o stays low.
- R6: A low pulse on rx_i shorter than MIN_BIT/2 clocks causes no error and no lock. A following valid character still locks.
- R7: A low time of at least MIN_BIT/2 clocks but under 7·MIN_BIT clocks gives a one-cycle err_o pulse and no lock.
- R8: A low time that reaches the counter limit 2^CNT_W−1 gives an err_o pulse and no lock.
- R9: A tail mismatch gives a single-cycle err_o pulse and a return to waiting. A mismatch is data bit 6 not high, data bit 7 not low, or the stop bit low. A following valid character locks.
- R10: Once locked, lock_o and divisor_o hold their values and rx_i activity is ignored. There is no error and no further transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high, asynchronous |
| arm_i | input | 1 | Release request for the host hold-off |
| tx_o | output | 1 | Serial transmit line, idle high |
| rts_n_o | output | 1 | Active-low ready-to-send; high holds the host off |
| divisor_o | output | 16 | Measured baud divisor |
| lock_o | output | 1 | Rate has been locked |
| err_o | output | 1 | One-cycle pulse on a rejected character |
| done_o | output | 1 | Acknowledge frame fully sent |

## Verification
Two events can land in the same cycle: the end of the last acknowledge stop bit and an arm request. The bench provokes this by holding arm_i high from before the sync character through the whole acknowledge. It judges the result with a per-cycle monitor that flags any cycle in which rts_n_o is low while done_o is still low, and then requires the release on the cycle after done_o. A second overlap is receive-line activity while the transmitter is busy or finished. The bench drives a malformed character after lock and expects no error pulse, no change in the divisor and no extra bytes on tx_o.

// File: rtl/ab_pkg.sv
package ab_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_CHECK,
        ST_FAIL,
        ST_ACK,
        ST_HOLD,
        ST_OPEN
    } ab_state_e;

    localparam int          DIV_W     = 16;
    localparam logic [7:0]  ACK_HEAD  = 8'hBF;
    localparam logic [7:0]  ACK_TAIL  = 8'h00;
    // expected samples after the first rising edge: bit6, bit7, stop
    localparam logic [2:0]  TAIL_BITS = 3'b101;
endpackage

// File: rtl/ab_sync.sv
module ab_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ab_tx.sv
module ab_tx #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       data,
    input  logic [CNT_W-1:0] period,
    output logic             tx,
    output logic             fin
);
    logic [9:0]       shreg;
    logic [3:0]       left;
    logic [CNT_W-1:0] tmr;
    logic             busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '1;
            left  <= '0;
            tmr   <= '0;
            busy  <= 1'b0;
        end else if (start && !busy) begin
            shreg <= {1'b1, data, 1'b0};
            left  <= 4'd10;
            tmr   <= period - 1'b1;
            busy  <= 1'b1;
        end else if (busy) begin
            if (tmr == '0) begin
                tmr   <= period - 1'b1;
                shreg <= {1'b1, shreg[9:1]};
                left  <= left - 4'd1;
                if (left == 4'd1) busy <= 1'b0;
            end else begin
                tmr <= tmr - 1'b1;
            end
        end
    end

    assign tx  = shreg[0];
    assign fin = busy && (tmr == '0) && (left == 4'd1);
endmodule

// File: rtl/autobaud_sync.sv
module autobaud_sync
    import ab_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_BIT = 16,
    parameter int OS_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             arm_i,
    output logic             tx_o,
    output logic             rts_n_o,
    output logic [DIV_W-1:0] divisor_o,
    output logic             lock_o,
    output logic             err_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] GLITCH_LT = CNT_W'(MIN_BIT / 2);
    localparam logic [CNT_W-1:0] SHORT_LT  = CNT_W'(7 * MIN_BIT);
    localparam logic [CNT_W:0]   DIV_HALF  = (CNT_W+1)'(1) << (OS_LOG2 - 1);

    ab_state_e        state, nxt;
    logic             rx_s;
    logic [CNT_W-1:0] cnt, period, tmr, per_calc;
    logic [CNT_W:0]   sum7, div_full;
    logic [1:0]       chk_idx, byte_idx;
    logic             need_send, tx_start, tx_fin;
    logic [7:0]       tx_byte;

    ab_sync #(.STAGES(2)) u_sync (.clk(clk), .rst_n(rst_n), .d(rx_i), .q(rx_s));

    // rounded bit period from seven low bit times
    assign sum7     = {1'b0, cnt} + (CNT_W+1)'(3);
    assign per_calc = CNT_W'(sum7 / (CNT_W+1)'(7));
    assign div_full = ({1'b0, period} + DIV_HALF) >> OS_LOG2;
    assign divisor_o = DIV_W'(div_full);

    always_comb begin
        unique case (byte_idx)
            2'd0: tx_byte = ACK_HEAD;
            2'd1: tx_byte = divisor_o[7:0];
            2'd2: tx_byte = divisor_o[15:8];
            2'd3: tx_byte = ACK_TAIL;
        endcase
    end

    assign tx_start = (state == ST_ACK) && need_send;

    ab_tx #(.CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .data(tx_byte),
        .period(period), .tx(tx_o), .fin(tx_fin)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!rx_s) nxt = ST_LOW;
            ST_LOW: begin
                if (rx_s) begin
                    if (cnt < GLITCH_LT)     nxt = ST_IDLE;
                    else if (cnt < SHORT_LT) nxt = ST_FAIL;
                    else                     nxt = ST_CHECK;
                end else if (cnt == CNT_MAX) begin
                    nxt = ST_FAIL;
                end
            end
            ST_CHECK: begin
                if (tmr == '0) begin
                    if (rx_s != TAIL_BITS[chk_idx]) nxt = ST_FAIL;
                    else if (chk_idx == 2'd2)       nxt = ST_ACK;
                end
            end
            ST_FAIL:  nxt = ST_IDLE;
            ST_ACK:   if (tx_fin && byte_idx == 2'd3) nxt = ST_HOLD;
            ST_HOLD:  if (arm_i) nxt = ST_OPEN;
            ST_OPEN:  nxt = ST_OPEN;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // measurement, tail sampling and byte sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            period    <= '0;
            tmr       <= '0;
            chk_idx   <= '0;
            byte_idx  <= '0;
            need_send <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: cnt <= CNT_W'(1);
                ST_LOW: begin
                    if (!rx_s && cnt != CNT_MAX) cnt <= cnt + 1'b1;
                    if (nxt == ST_CHECK) begin
                        period  <= per_calc;
                        tmr     <= per_calc >> 1;
                        chk_idx <= '0;
                    end
                end
                ST_CHECK: begin
                    if (tmr == '0) begin
                        tmr     <= period - 1'b1;
                        chk_idx <= chk_idx + 2'd1;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                    if (nxt == ST_ACK) begin
                        byte_idx  <= '0;
                        need_send <= 1'b1;
                    end
                end
                ST_ACK: begin
                    if (need_send) need_send <= 1'b0;
                    if (tx_fin) begin
                        byte_idx  <= byte_idx + 2'd1;
                        need_send <= (byte_idx != 2'd3);
                    end
                end
                default: ;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        lock_o  = 1'b0;
        done_o  = 1'b0;
        err_o   = 1'b0;
        rts_n_o = 1'b1;
        unique case (state)
            ST_FAIL: err_o = 1'b1;
            ST_ACK:  lock_o = 1'b1;
            ST_HOLD: begin lock_o = 1'b1; done_o = 1'b1; end
            ST_OPEN: begin lock_o = 1'b1; done_o = 1'b1; rts_n_o = 1'b0; end
            default: ;
        endcase
    end
endmodule

// File: rtl/ab_chk.sv
module ab_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        arm_i,
    input logic        tx_o,
    input logic        rts_n_o,
    input logic [15:0] divisor_o,
    input logic        lock_o,
    input logic        err_o,
    input logic        done_o
);
    assert_tx_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |-> tx_o);

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    assert_done_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> tx_o);

    assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> rts_n_o);

    assert_release_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts_n_o) |-> ($past(done_o) && $past(arm_i)));

    assert_release_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_n_o |=> !rts_n_o);

    assert_err_nolock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !lock_o);

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> (lock_o && $stable(divisor_o)));

    assert_lock_noerr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> !err_o);
endmodule

bind autobaud_sync ab_chk u_chk (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .tx_o(tx_o), .rts_n_o(rts_n_o),
    .divisor_o(divisor_o), .lock_o(lock_o), .err_o(err_o), .done_o(done_o)
);

// File: tb/tb_autobaud_sync.sv
module tb_autobaud_sync;
    localparam int CNT_W   = 14;
    localparam int MIN_BIT = 16;
    localparam int OS_LOG2 = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic        arm = 1'b0;
    logic        tx_o, rts_n_o, lock_o, err_o, done_o;
    logic [15:0] divisor_o;

    int checks = 0, fails = 0, errs = 0, rts_bad = 0, nbytes = 0, cur_p = 16;
    logic [7:0] got [0:7];
    bit finished = 0;

    always #4 clk = ~clk;

    autobaud_sync #(.CNT_W(CNT_W), .MIN_BIT(MIN_BIT), .OS_LOG2(OS_LOG2)) dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .arm_i(arm), .tx_o(tx_o),
        .rts_n_o(rts_n_o), .divisor_o(divisor_o), .lock_o(lock_o),
        .err_o(err_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && err_o) errs++;
        if (rst_n && !rts_n_o && !done_o) rts_bad++;
    end

    // decode the acknowledge bytes from tx_o
    initial begin
        forever begin
            logic [7:0] b;
            @(negedge tx_o);
            repeat (cur_p / 2) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                repeat (cur_p) @(negedge clk);
                b[i] = tx_o;
            end
            repeat (cur_p) @(negedge clk);
            got[nbytes % 8] = b;
            nbytes++;
        end
    end

    task automatic reset_dut();
        rst_n = 1'b0; rx = 1'b1; arm = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        errs = 0; nbytes = 0; rts_bad = 0;
        @(negedge clk);
    endtask

    task automatic drive_low(input int n);
        rx = 1'b0;
        repeat (n) @(negedge clk);
        rx = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] d, input int p, input bit stop);
        for (int i = 0; i < 10; i++) begin
            rx = (i == 0) ? 1'b0 : (i == 9) ? stop : d[i-1];
            repeat (p) @(negedge clk);
        end
        rx = 1'b1;
    endtask

    task automatic wait_done(input int lim);
        for (int i = 0; i < lim && !done_o; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic lock_run(input int p);
        int exp_div;
        reset_dut();
        cur_p = p;
        exp_div = (p + 2) >> OS_LOG2;
        send_frame(8'h40, p, 1'b1);
        wait_done(50 * p + 200);
        check(lock_o == 1'b1, "R2 lock", lock_o, 1);
        check(divisor_o == exp_div, "R2 divisor", divisor_o, exp_div);
        check(nbytes == 4, "R3 byte count", nbytes, 4);
        check(got[0] == 8'hBF, "R3 byte0", got[0], 8'hBF);
        check(got[1] == exp_div[7:0], "R3 byte1", got[1], exp_div & 255);
        check(got[2] == exp_div[15:8], "R3 byte2", got[2], (exp_div >> 8) & 255);
        check(got[3] == 8'h00, "R3 byte3", got[3], 0);
        check(done_o == 1'b1, "R4 done", done_o, 1);
        check(rts_n_o == 1'b1, "R5 held before arm", rts_n_o, 1);
        check(errs == 0, "R2 no error", errs, 0);
        arm = 1'b1;
        repeat (3) @(negedge clk);
        check(rts_n_o == 1'b0, "R5 released", rts_n_o, 0);
        check(rts_bad == 0, "R5 no early release", rts_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_o == 1'b1, "R1 tx", tx_o, 1);
        check(rts_n_o == 1'b1, "R1 rts_n", rts_n_o, 1);
        check(lock_o == 1'b0, "R1 lock", lock_o, 0);
        check(done_o == 1'b0, "R1 done", done_o, 0);
        check(err_o == 1'b0, "R1 err", err_o, 0);
        check(divisor_o == 16'd0, "R1 divisor", divisor_o, 0);

        // R2/R3/R4/R5 sweep across bit periods, including the minimum
        for (int p = MIN_BIT; p <= 32; p++) lock_run(p);
        // R3 high divisor byte non-zero
        lock_run(1100);

        // R6 glitch below threshold ignored
        reset_dut();
        cur_p = 20;
        drive_low(MIN_BIT / 2 - 1);
        repeat (40) @(negedge clk);
        check(errs == 0, "R6 glitch no error", errs, 0);
        check(lock_o == 1'b0, "R6 glitch no lock", lock_o, 0);
        send_frame(8'h40, 20, 1'b1);
        wait_done(1200);
        check(lock_o == 1'b1, "R6 lock after glitch", lock_o, 1);
        check(divisor_o == 16'd5, "R6 divisor after glitch", divisor_o, 5);

        // R7 low at the glitch threshold is rejected
        reset_dut();
        drive_low(MIN_BIT / 2);
        repeat (40) @(negedge clk);
        check(errs == 1, "R7 threshold error", errs, 1);
        check(lock_o == 1'b0, "R7 threshold no lock", lock_o, 0);

        // R7 one clock under 7*MIN_BIT is rejected
        reset_dut();
        drive_low(7 * MIN_BIT - 1);
        repeat (40) @(negedge clk);
        check(errs == 1, "R7 short error", errs, 1);
        check(lock_o == 1'b0, "R7 short no lock", lock_o, 0);

        // R8 counter limit
        reset_dut();
        drive_low((1 << CNT_W) + 16);
        repeat (40) @(negedge clk);
        check(errs >= 1, "R8 overflow error", errs, 1);
        check(lock_o == 1'b0, "R8 overflow no lock", lock_o, 0);

        // R9 tail mismatch: bit7 high, then a low stop bit
        reset_dut();
        cur_p = 20;
        send_frame(8'hC0, 20, 1'b1);
        repeat (40) @(negedge clk);
        check(errs == 1, "R9 bit7 mismatch error", errs, 1);
        check(lock_o == 1'b0, "R9 bit7 no lock", lock_o, 0);
        send_frame(8'h40, 20, 1'b0);
        repeat (60) @(negedge clk);
        check(errs >= 2, "R9 stop mismatch error", errs, 2);
        check(lock_o == 1'b0, "R9 stop no lock", lock_o, 0);
        send_frame(8'h40, 20, 1'b1);
        wait_done(1200);
        check(lock_o == 1'b1, "R9 recovers", lock_o, 1);
        check(divisor_o == 16'd5, "R9 divisor", divisor_o, 5);

        // R10 rx ignored after lock
        reset_dut();
        cur_p = 24;
        send_frame(8'h40, 24, 1'b1);
        wait_done(1500);
        send_frame(8'hC0, 24, 1'b1);
        drive_low(50);
        repeat (60) @(negedge clk);
        check(errs == 0, "R10 no error", errs, 0);
        check(lock_o == 1'b1, "R10 lock held", lock_o, 1);
        check(divisor_o == 16'd6, "R10 divisor held", divisor_o, 6);
        check(nbytes == 4, "R10 no extra bytes", nbytes, 4);

        // R5 arm held from the start coincides with done
        reset_dut();
        arm = 1'b1;
        cur_p = 18;
        send_frame(8'h40, 18, 1'b1);
        wait_done(1100);
        check(done_o == 1'b1, "R4 done with arm", done_o, 1);
        check(rts_n_o == 1'b0, "R5 release after done", rts_n_o, 0);
        check(rts_bad == 0, "R5 early arm ignored", rts_bad, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1-all: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule